// File: doc/BRIEF.md
# Segmented Wakeup Window

This block tracks the operand readiness of the instructions waiting in an issue window. The window's entries are split into equal segments placed one after another. A result tag broadcast on the wakeup port is compared against the first segment in the cycle it arrives. A register stage then passes it on, and it meets the next segment one cycle later. The wakeup wires therefore never span more than one segment in a cycle. In exchange, an entry further down the window wakes a fixed number of cycles later.

Each entry keeps two source tags and a ready bit for each of them. A dispatch port writes one entry per cycle at a chosen index. Any entry can be freed by a grant bit from the issue logic. A flush input empties the whole window and drops every tag still moving between segments. The block exports a valid vector and a ready vector with one bit per entry. Choosing which ready entry to issue is left to a separate selector.

Top module: `wake_window`

## Requirements
- R1: Reset (synchronous, rst_n low) clears every entry and every inter-segment tag register. A tag presented during reset never wakes an entry that is dispatched after reset.
- R2: A dispatch writes entry disp_idx, which reads as valid after the next clock edge. The entry reads as ready after that edge if both of its operand-ready flags were given with it.
- R3: A tag broadcast in the cycle that ends at edge E sets matching ready bits in segment s at edge E+s. Segment 0 sees the tag directly, and each later segment sees it through one more register.
- R4: Entry i belongs to segment i / (ENTRIES/SEGS), where the division is an integer division.
- R5: Any valid broadcast lane whose tag equals either stored source tag marks that operand ready. A lane with its valid bit low never matches, and neither does a different tag.
- R6: entry_ready of an entry is high only when the entry is valid and both of its operands are ready. The two operands may wake in the same cycle or in different cycles.
- R7: A dispatch also compares its two source tags against the tags presented to its own segment in that cycle. A wakeup there is not lost. A tag that has already passed the segment does not wake the entry.
- R8: Operand ready bits stay set until the entry is freed.
- R9: A grant bit on a valid entry clears that entry's valid and ready outputs after the next edge.
- R10: Flush clears all entries and all in-flight tags at the next edge. A tag broadcast before the flush never wakes an entry that is dispatched after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the window and drop in-flight tags |
| bc_valid | input | BCAST | Valid bit for each broadcast lane |
| bc_tag | input | BCAST*TAG_W | Broadcast tags; lane l at bits l*TAG_W upward |
| disp_valid | input | 1 | Write an entry this cycle |
| disp_idx | input | $clog2(ENTRIES) | Index of the entry written |
| disp_src0 | input | TAG_W | First source tag |
| disp_src1 | input | TAG_W | Second source tag |
| disp_rdy0 | input | 1 | First operand already ready |
| disp_rdy1 | input | 1 | Second operand already ready |
| grant | input | ENTRIES | Free the flagged entries |
| entry_valid | output | ENTRIES | Entry occupied |
| entry_ready | output | ENTRIES | Entry occupied with both operands ready |

## Verification
The embedded properties take three things about the inputs for granted. A dispatch only targets a free entry. A grant only names an occupied entry. Flush is never raised together with a dispatch. The bench keeps within these rules: it tracks which entries it has filled, grants only those, and frees every entry before it reuses the index. The sweep runs every entry in a small four-segment configuration against every lane and both operands. For each run the bench works out from the entry's segment the exact edge at which readiness must appear.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the per-entry update kind.
// Assumes nothing; holds no logic.
package wake_pkg;
    localparam int DEF_ENTRIES = 32;
    localparam int DEF_SEGS    = 4;
    localparam int DEF_TAG_W   = 6;
    localparam int DEF_BCAST   = 4;

    // What an entry does at the next edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_FREE = 2'd2
    } ent_op_e;
endpackage

// File: rtl/wk_tag_cmp.sv
`timescale 1ns/1ps
// wk_tag_cmp: compares one source tag against every broadcast lane.
// A lane whose valid bit is low never matches. Purely combinational.
module wk_tag_cmp #(
    parameter int TAG_W = 6,
    parameter int BCAST = 4
) (
    input  logic [TAG_W-1:0]       src_tag,
    input  logic [BCAST-1:0]       lane_vld,
    input  logic [BCAST*TAG_W-1:0] lane_tag,
    output logic                   hit
);
    // OR of the lane matches.
    always_comb begin
        hit = 1'b0;
        for (int l = 0; l < BCAST; l++) begin
            if (lane_vld[l] && (lane_tag[l*TAG_W +: TAG_W] == src_tag)) begin
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wk_tag_stage.sv
`timescale 1ns/1ps
// wk_tag_stage: register that carries the broadcast tags from one
// segment to the next. Reset and flush empty it.
// Assumes a single clock shared with the entries.
module wk_tag_stage #(
    parameter int TAG_W = 6,
    parameter int BCAST = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic [BCAST-1:0]       d_vld,
    input  logic [BCAST*TAG_W-1:0] d_tag,
    output logic [BCAST-1:0]       q_vld,
    output logic [BCAST*TAG_W-1:0] q_tag
);
    // Capture the tags presented upstream; drop them on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            q_vld <= '0;
            q_tag <= '0;
        end else begin
            q_vld <= d_vld;
            q_tag <= d_tag;
        end
    end

    // A lane valid downstream must have been valid upstream one cycle earlier.
    for (genvar l = 0; l < BCAST; l++) begin : g_chk
        p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
            q_vld[l] |-> $past(d_vld[l] && !flush_i));
    end
endmodule

// File: rtl/wk_seg.sv
`timescale 1ns/1ps
// wk_seg: one segment of the wakeup window, holding EPS entries.
// Every entry compares its two source tags against the tags presented
// to this segment in the current cycle. A dispatch into the segment
// compares its own tags against the same lanes.
// Assumes a dispatch targets only a free entry, a grant names only a
// valid entry, and flush does not coincide with a dispatch.
module wk_seg
    import wake_pkg::*;
#(
    parameter int EPS    = 8,
    parameter int TAG_W  = 6,
    parameter int BCAST  = 4,
    parameter int LIDX_W = (EPS > 1) ? $clog2(EPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic [BCAST-1:0]       pres_vld_i,
    input  logic [BCAST*TAG_W-1:0] pres_tag_i,
    input  logic                   disp_en_i,
    input  logic [LIDX_W-1:0]      disp_loc_i,
    input  logic [TAG_W-1:0]       disp_src0_i,
    input  logic [TAG_W-1:0]       disp_src1_i,
    input  logic                   disp_rdy0_i,
    input  logic                   disp_rdy1_i,
    input  logic [EPS-1:0]         grant_i,
    output logic [EPS-1:0]         valid_o,
    output logic [EPS-1:0]         ready_o
);
    logic dhit0, dhit1;

    // Dispatch-time match of the incoming source tags.
    wk_tag_cmp #(.TAG_W(TAG_W), .BCAST(BCAST)) i_dcmp0 (
        .src_tag(disp_src0_i), .lane_vld(pres_vld_i),
        .lane_tag(pres_tag_i), .hit(dhit0)
    );
    wk_tag_cmp #(.TAG_W(TAG_W), .BCAST(BCAST)) i_dcmp1 (
        .src_tag(disp_src1_i), .lane_vld(pres_vld_i),
        .lane_tag(pres_tag_i), .hit(dhit1)
    );

    for (genvar e = 0; e < EPS; e++) begin : g_ent
        logic             vld, r0, r1;
        logic [TAG_W-1:0] t0, t1;
        logic             hit0, hit1;
        logic             sel;
        ent_op_e          op;

        // Match of the stored tags against the presented lanes.
        wk_tag_cmp #(.TAG_W(TAG_W), .BCAST(BCAST)) i_cmp0 (
            .src_tag(t0), .lane_vld(pres_vld_i),
            .lane_tag(pres_tag_i), .hit(hit0)
        );
        wk_tag_cmp #(.TAG_W(TAG_W), .BCAST(BCAST)) i_cmp1 (
            .src_tag(t1), .lane_vld(pres_vld_i),
            .lane_tag(pres_tag_i), .hit(hit1)
        );

        assign sel = disp_en_i && (disp_loc_i == LIDX_W'(e));

        // Choose the entry update: flush, then load, then free.
        always_comb begin
            if (flush_i)         op = OP_FREE;
            else if (sel)        op = OP_LOAD;
            else if (grant_i[e]) op = OP_FREE;
            else                 op = OP_HOLD;
        end

        // Entry state: tags, occupancy and sticky operand-ready bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= 1'b0;
                r0  <= 1'b0;
                r1  <= 1'b0;
                t0  <= '0;
                t1  <= '0;
            end else begin
                case (op)
                    OP_LOAD: begin
                        vld <= 1'b1;
                        t0  <= disp_src0_i;
                        t1  <= disp_src1_i;
                        r0  <= disp_rdy0_i || dhit0;
                        r1  <= disp_rdy1_i || dhit1;
                    end
                    OP_FREE: begin
                        vld <= 1'b0;
                        r0  <= 1'b0;
                        r1  <= 1'b0;
                    end
                    default: begin
                        if (vld) begin
                            r0 <= r0 || hit0;
                            r1 <= r1 || hit1;
                        end
                    end
                endcase
            end
        end

        assign valid_o[e] = vld;
        assign ready_o[e] = vld && r0 && r1;

        // Input rule: dispatch only into a free entry.
        p_disp_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
            sel |-> !vld);
        // Input rule: grant only an occupied entry.
        p_grant_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
            grant_i[e] |-> vld);
        // A granted entry is gone after the edge.
        p_grant_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_i[e] && !sel) |=> !valid_o[e]);
        // A lane match on a held entry sets the operand.
        p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (vld && !flush_i && !grant_i[e] && hit0) |=> r0);
        // Ready bits never drop while the entry is held.
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (vld && r1 && !flush_i && !grant_i[e]) |=> r1);
    end
endmodule

// File: rtl/wake_window.sv
`timescale 1ns/1ps
// wake_window: issue-window wakeup with the broadcast spread over SEGS
// segments. Segment 0 sees the broadcast lanes directly, and segment s
// sees them s cycles later through a chain of tag registers.
// Assumes ENTRIES is a multiple of SEGS, ENTRIES >= 2, and at most one
// dispatch per cycle.
module wake_window
    import wake_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int SEGS    = DEF_SEGS,
    parameter int TAG_W   = DEF_TAG_W,
    parameter int BCAST   = DEF_BCAST,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [BCAST-1:0]       bc_valid,
    input  logic [BCAST*TAG_W-1:0] bc_tag,
    input  logic                   disp_valid,
    input  logic [IDX_W-1:0]       disp_idx,
    input  logic [TAG_W-1:0]       disp_src0,
    input  logic [TAG_W-1:0]       disp_src1,
    input  logic                   disp_rdy0,
    input  logic                   disp_rdy1,
    input  logic [ENTRIES-1:0]     grant,
    output logic [ENTRIES-1:0]     entry_valid,
    output logic [ENTRIES-1:0]     entry_ready
);
    localparam int EPS    = ENTRIES / SEGS;
    localparam int LIDX_W = (EPS > 1) ? $clog2(EPS) : 1;

    logic [SEGS-1:0][BCAST-1:0]       pres_vld;
    logic [SEGS-1:0][BCAST*TAG_W-1:0] pres_tag;
    logic [IDX_W-1:0]                 seg_of;
    logic [LIDX_W-1:0]                loc_of;

    // Split the dispatch index into segment and slot.
    assign seg_of = disp_idx / IDX_W'(EPS);
    assign loc_of = LIDX_W'(disp_idx % IDX_W'(EPS));

    assign pres_vld[0] = bc_valid;
    assign pres_tag[0] = bc_tag;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        if (s < SEGS - 1) begin : g_link
            wk_tag_stage #(.TAG_W(TAG_W), .BCAST(BCAST)) i_stage (
                .clk(clk), .rst_n(rst_n), .flush_i(flush),
                .d_vld(pres_vld[s]), .d_tag(pres_tag[s]),
                .q_vld(pres_vld[s+1]), .q_tag(pres_tag[s+1])
            );
        end

        wk_seg #(.EPS(EPS), .TAG_W(TAG_W), .BCAST(BCAST), .LIDX_W(LIDX_W)) i_seg (
            .clk(clk), .rst_n(rst_n), .flush_i(flush),
            .pres_vld_i(pres_vld[s]), .pres_tag_i(pres_tag[s]),
            .disp_en_i(disp_valid && (seg_of == IDX_W'(s))),
            .disp_loc_i(loc_of),
            .disp_src0_i(disp_src0), .disp_src1_i(disp_src1),
            .disp_rdy0_i(disp_rdy0), .disp_rdy1_i(disp_rdy1),
            .grant_i(grant[s*EPS +: EPS]),
            .valid_o(entry_valid[s*EPS +: EPS]),
            .ready_o(entry_ready[s*EPS +: EPS])
        );
    end

    // Flush leaves no entry behind.
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (entry_valid == '0));
    // Ready is reported only for occupied entries.
    p_ready_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_ready & ~entry_valid) == '0);
endmodule

// File: tb/test_wake_window.sv
`timescale 1ns/1ps
// Bench: 8 entries in 4 segments, 2 lanes of 4-bit tags.
module test_wake_window;
    localparam int N  = 8;
    localparam int SG = 4;
    localparam int TW = 4;
    localparam int BC = 2;
    localparam int EP = N / SG;
    localparam int IW = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic [BC-1:0]     bc_valid = '0;
    logic [BC*TW-1:0]  bc_tag = '0;
    logic              disp_valid = 1'b0;
    logic [IW-1:0]     disp_idx = '0;
    logic [TW-1:0]     disp_src0 = '0, disp_src1 = '0;
    logic              disp_rdy0 = 1'b0, disp_rdy1 = 1'b0;
    logic [N-1:0]      grant = '0;
    logic [N-1:0]      entry_valid, entry_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    wake_window #(.ENTRIES(N), .SEGS(SG), .TAG_W(TW), .BCAST(BC)) i_wake_window (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .disp_valid(disp_valid), .disp_idx(disp_idx),
        .disp_src0(disp_src0), .disp_src1(disp_src1),
        .disp_rdy0(disp_rdy0), .disp_rdy1(disp_rdy1),
        .grant(grant), .entry_valid(entry_valid), .entry_ready(entry_ready)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        flush = 1'b0; bc_valid = '0; bc_tag = '0; disp_valid = 1'b0;
        disp_rdy0 = 1'b0; disp_rdy1 = 1'b0; grant = '0;
    endtask

    task automatic put_bc(input int lane, input logic v, input logic [TW-1:0] t);
        bc_valid[lane] = v;
        bc_tag[lane*TW +: TW] = t;
    endtask

    task automatic put_disp(input int idx, input logic [TW-1:0] s0, input logic [TW-1:0] s1,
                            input logic r0, input logic r1);
        disp_valid = 1'b1; disp_idx = IW'(idx);
        disp_src0 = s0; disp_src1 = s1; disp_rdy0 = r0; disp_rdy1 = r1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic free_all(input logic [N-1:0] m);
        idle(); grant = m; step(); idle();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with a tag on the lanes.
        #1;
        put_bc(0, 1'b1, 4'd5);
        step(); step();
        chk("R1", "valid after reset", entry_valid, '0);
        chk("R1", "ready after reset", entry_ready, '0);
        rst_n = 1'b1; idle();
        put_disp(2, 4'd5, 4'd0, 1'b0, 1'b1);   // entry 2 in segment 1
        step(); idle();
        chk("R1", "stale tag valid", entry_valid, N'(1) << 2);
        chk("R1", "stale tag ready", entry_ready, '0);
        free_all(N'(1) << 2);
        chk("R9", "grant frees", entry_valid, '0);

        // R3/R4/R5 sweep: every entry, lane and operand.
        for (int e = 0; e < N; e++) begin
            for (int ln = 0; ln < BC; ln++) begin
                for (int op = 0; op < 2; op++) begin
                    automatic int sg = e / EP;
                    automatic logic [TW-1:0] tg = TW'((e * 3 + ln + op) % 15 + 1);
                    if (op == 0) put_disp(e, tg, 4'd0, 1'b0, 1'b1);
                    else         put_disp(e, 4'd0, tg, 1'b1, 1'b0);
                    step(); idle();
                    chk("R2", "dispatch valid", entry_valid, N'(1) << e);
                    chk("R6", "half ready", entry_ready, '0);
                    put_bc(ln, 1'b1, tg);
                    step(); idle();
                    for (int k = 0; k <= sg; k++) begin
                        if (k > 0) step();
                        chk("R3", $sformatf("entry %0d seg %0d edge +%0d", e, sg, k),
                            entry_ready, (k == sg) ? (N'(1) << e) : '0);
                    end
                    free_all(N'(1) << e);
                    chk("R9", "freed", entry_valid | entry_ready, '0);
                end
            end
        end

        // R5: invalid lane and different tag never match.
        put_disp(0, 4'd3, 4'd0, 1'b0, 1'b1);
        step(); idle();
        put_bc(0, 1'b0, 4'd3); put_bc(1, 1'b1, 4'd4);
        step(); idle();
        for (int k = 0; k < SG; k++) step();
        chk("R5", "invalid lane / other tag", entry_ready, '0);
        free_all(N'(1));

        // R6: operands wake in different cycles.
        put_disp(7, 4'd6, 4'd9, 1'b0, 1'b0);
        step(); idle();
        put_bc(0, 1'b1, 4'd6);
        step(); idle();
        for (int k = 0; k < SG; k++) step();
        chk("R6", "one operand only", entry_ready, '0);
        put_bc(1, 1'b1, 4'd9);
        step(); idle();
        step(); step(); step();
        chk("R6", "second operand at edge +3", entry_ready, N'(1) << 7);
        free_all(N'(1) << 7);

        // R6: both operands in one cycle on two lanes, segment 0.
        put_disp(1, 4'd6, 4'd9, 1'b0, 1'b0);
        step(); idle();
        put_bc(0, 1'b1, 4'd9); put_bc(1, 1'b1, 4'd6);
        step(); idle();
        chk("R6", "both lanes same cycle", entry_ready, N'(1) << 1);
        free_all(N'(1) << 1);

        // R7: dispatch in the cycle the tag is at its segment, and one cycle late.
        for (int e = 0; e < N; e++) begin
            for (int late = 0; late < 2; late++) begin
                automatic int sg = e / EP;
                automatic int at = sg + late;
                put_bc(0, 1'b1, 4'd11);
                if (at == 0) put_disp(e, 4'd11, 4'd0, 1'b0, 1'b1);
                step(); idle();
                for (int j = 1; j <= at; j++) begin
                    if (j == at) put_disp(e, 4'd11, 4'd0, 1'b0, 1'b1);
                    step(); idle();
                end
                chk("R7", $sformatf("entry %0d late %0d valid", e, late),
                    entry_valid, N'(1) << e);
                chk("R7", $sformatf("entry %0d late %0d ready", e, late),
                    entry_ready, (late == 0) ? (N'(1) << e) : '0);
                for (int k = 0; k < SG; k++) step();
                free_all(N'(1) << e);
            end
        end

        // R2 and R8: pre-ready dispatch, then ready stays up.
        put_disp(5, 4'd2, 4'd7, 1'b1, 1'b1);
        step(); idle();
        chk("R2", "pre-ready dispatch", entry_ready, N'(1) << 5);
        for (int k = 0; k < 6; k++) begin
            put_bc(0, 1'b1, TW'(k)); put_bc(1, 1'b1, 4'd7);
            step(); idle();
            chk("R8", "sticky ready", entry_ready, N'(1) << 5);
        end
        free_all(N'(1) << 5);

        // R10: flush empties the window.
        put_disp(0, 4'd1, 4'd1, 1'b1, 1'b1); step(); idle();
        put_disp(3, 4'd1, 4'd1, 1'b0, 1'b0); step(); idle();
        put_disp(6, 4'd1, 4'd1, 1'b1, 1'b1); step(); idle();
        chk("R10", "before flush", entry_valid, 8'b0100_1001);
        flush = 1'b1; step(); idle();
        chk("R10", "flush valid", entry_valid, '0);
        chk("R10", "flush ready", entry_ready, '0);

        // R10: in-flight tag dropped. Without the flush it would meet
        // entry 5 (segment 2) in the dispatch cycle.
        put_bc(0, 1'b1, 4'd12);
        step(); idle();
        flush = 1'b1; step(); idle();
        put_disp(5, 4'd12, 4'd0, 1'b0, 1'b1);
        step(); idle();
        chk("R10", "in-flight tag dropped valid", entry_valid, N'(1) << 5);
        chk("R10", "in-flight tag dropped ready", entry_ready, '0);
        free_all(N'(1) << 5);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule